// File: doc/BRIEF.md
# Filtered Edge Capture Timer

A 16-bit counter with two capture registers, each loaded from its own trigger pin. In front of each pin sits a two-stage synchronizer and a digital filter. The filter takes a new pin level only after two sample ticks in a row have seen it. Each pin has its own edge selection. An accepted edge of the selected polarity copies the counter into that channel's capture register and raises a one-cycle flag. Software finds a pulse width by subtracting two captures modulo 2^16. The result is only meaningful when the pulse is shorter than one full counter wrap.

The block has two operating roles. In free-run mode the counter advances on every clock. Both pins act as capture triggers, and their filters sample on a tick divided from the clock by the prescaler select. In event mode pin 0 becomes the count source. Its filter then samples on every clock, whatever the prescaler says. The counter advances once per accepted edge of pin 0, and the event total is read from the counter output. Pin 1 keeps its capture role in both modes.

Top module: `capTimer`

## Requirements
- R1: After reset the counter, both capture registers and all three flags read zero.
- R2: In free-run mode (modeSel=0) the counter rises by one every clock. On the step from FFFFh to 0000h, ovfFlag is high for exactly the cycle in which the counter reads 0000h.
- R3: Each edge-select field decodes as follows: 2'b00 no edge, 2'b01 rising only, 2'b10 falling only, 2'b11 both. An edge that is not selected causes no capture and no flag.
- R4: A new pin level is accepted only when two consecutive sample ticks both see it. With prescSel=0, a one-cycle pulse is ignored and a two-cycle pulse is accepted. With prescSel=2, a three-cycle pulse is ignored.
- R5: The capture register takes the counter value of the cycle in which the edge is accepted. With prescSel=0, a pin change driven before clock edge E0 loads the counter value held just before edge E3. The flag is high during the cycle after E3.
- R6: In the capture role, filter sample ticks come every 2^prescSel clocks. The pin-to-capture delay therefore lies between 2^prescSel+2 and 2^(prescSel+1)+1 clocks.
- R7: In event mode (modeSel=1), pin 0 is sampled every clock whatever prescSel is. The counter advances by one per accepted pin-0 edge of the polarity chosen by edgeSel0, and holds when pin 0 is idle. Pin 0 never loads capVal0 and never raises capFlag0.
- R8: The two channels are independent. A capture on one channel leaves the other channel's register and flag untouched. Pin 1 captures in both modes.
- R9: Each accepted, selected edge produces a flag pulse exactly one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | 0 free-run with captures, 1 pin 0 counts events |
| prescSel | input | 2 | Capture-role sample tick every 2^prescSel clocks |
| edgeSel0 | input | 2 | Edge selection for pin 0 |
| edgeSel1 | input | 2 | Edge selection for pin 1 |
| trigIn0 | input | 1 | Trigger / event pin 0 (asynchronous) |
| trigIn1 | input | 1 | Trigger pin 1 (asynchronous) |
| countVal | output | 16 | Current counter value |
| capVal0 | output | 16 | Capture register of channel 0 |
| capVal1 | output | 16 | Capture register of channel 1 |
| capFlag0 | output | 1 | One-cycle capture pulse, channel 0 |
| capFlag1 | output | 1 | One-cycle capture pulse, channel 1 |
| ovfFlag | output | 1 | One-cycle counter wrap pulse |

## Verification
The bench targets the filter boundary: a one-cycle pulse must vanish and a two-cycle pulse must be taken. A filter that takes a single sample would capture the glitch, and one that needs three samples would drop the short pulse. Capture values are compared against the exact cycle in which the flag appears, and against the delay window for each prescaler setting. A design that samples on the wrong tick, or latches the counter one cycle late, therefore shows an offset. Event mode is run with the slowest prescaler and three-cycle pulses. A filter that wrongly kept the divided tick would miss these pulses, and a counter that kept free-running would overshoot. The wrap from FFFFh, and the one-cycle length of every flag, are checked at the ports.

// File: rtl/capTimerPkg.sv
package capTimerPkg;

  localparam int NUM_CH = 2;

  // Edge-select encoding: bit 0 enables rising, bit 1 enables falling
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic capLd0;
    logic capLd1;
  } dpStrobe_t;

endpackage

// File: rtl/capTimerFilt.sv
module capTimerFilt
  import capTimerPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     pinIn,
  input  edgeSel_e edgeSel,
  output logic     edgeHit
);

  logic [1:0] syncQ;
  logic       histQ;
  logic       lvlQ;
  logic       accept;
  logic       riseSeen;

  // Two-stage synchronizer runs on every clock
  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[0], pinIn};
    end
  end

  // Previous sample and accepted level move only on a sample tick
  always_ff @(posedge clk) begin
    if (!rstN) begin
      histQ <= 1'b0;
      lvlQ  <= 1'b0;
    end else begin
      if (tickEn) begin
        histQ <= syncQ[1];
      end
      if (accept) begin
        lvlQ <= syncQ[1];
      end
    end
  end

  // New level seen on this tick and the previous tick
  always_comb begin
    accept   = tickEn && (histQ == syncQ[1]) && (syncQ[1] != lvlQ);
    riseSeen = syncQ[1];
    edgeHit  = 1'b0;
    if (accept) begin
      unique case (edgeSel)
        EDGE_NONE: edgeHit = 1'b0;
        EDGE_RISE: edgeHit = riseSeen;
        EDGE_FALL: edgeHit = !riseSeen;
        EDGE_BOTH: edgeHit = 1'b1;
        default:   edgeHit = 1'b0;
      endcase
    end
  end

  AST_LVL_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lvlQ) |-> $past(tickEn)); // R6

  AST_LVL_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lvlQ) |-> ($past(histQ) == lvlQ)); // R4

endmodule

// File: rtl/capTimerCtrl.sv
module capTimerCtrl
  import capTimerPkg::*;
#(
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtMode,
  input  logic [PSEL_W-1:0] prescSel,
  input  logic [NUM_CH-1:0] pins,
  input  edgeSel_e          edgeSel0,
  input  edgeSel_e          edgeSel1,
  output dpStrobe_t         strobe
);

  localparam int PRE_W = (1 << PSEL_W) - 1;

  logic [PRE_W-1:0]  prescCnt;
  logic [PRE_W-1:0]  prescMask;
  logic              presTick;
  logic [NUM_CH-1:0] tickArr;
  logic [NUM_CH-1:0] hitArr;
  edgeSel_e          selArr [NUM_CH];

  // Free-running prescaler; a tick each 2^prescSel clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prescCnt <= '0;
    end else begin
      prescCnt <= prescCnt + 1'b1;
    end
  end

  always_comb begin
    prescMask = ~({PRE_W{1'b1}} << prescSel);
    presTick  = ((prescCnt & prescMask) == '0);
    // Pin 0 in count role samples every clock
    tickArr[0] = evtMode ? 1'b1 : presTick;
    tickArr[1] = presTick;
    selArr[0]  = edgeSel0;
    selArr[1]  = edgeSel1;
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : gFilt
    capTimerFilt uFilt (
      .clk    (clk),
      .rstN   (rstN),
      .tickEn (tickArr[ch]),
      .pinIn  (pins[ch]),
      .edgeSel(selArr[ch]),
      .edgeHit(hitArr[ch])
    );
  end

  always_comb begin
    strobe.cntInc = evtMode ? hitArr[0] : 1'b1;
    strobe.capLd0 = !evtMode && hitArr[0];
    strobe.capLd1 = hitArr[1];
  end

endmodule

// File: rtl/capTimerDp.sv
module capTimerDp
  import capTimerPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] cap0Q,
  output logic [CNT_W-1:0] cap1Q,
  output logic             flag0Q,
  output logic             flag1Q,
  output logic             ovfQ
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
      ovfQ <= 1'b0;
    end else begin
      ovfQ <= strobe.cntInc && (cntQ == CNT_MAX);
      if (strobe.cntInc) begin
        cntQ <= cntQ + CNT_ONE;
      end
    end
  end

  // Capture takes the count held in the accepting cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cap0Q  <= '0;
      cap1Q  <= '0;
      flag0Q <= 1'b0;
      flag1Q <= 1'b0;
    end else begin
      flag0Q <= strobe.capLd0;
      flag1Q <= strobe.capLd1;
      if (strobe.capLd0) begin
        cap0Q <= cntQ;
      end
      if (strobe.capLd1) begin
        cap1Q <= cntQ;
      end
    end
  end

  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovfQ |-> (cntQ == '0)); // R2

  AST_FLAG0_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flag0Q |=> !flag0Q); // R9

  AST_FLAG1_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flag1Q |=> !flag1Q); // R9

  AST_CAP0_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cap0Q) |-> flag0Q); // R8

  AST_CAP1_ON_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cap1Q) |-> flag1Q); // R8

endmodule

// File: rtl/capTimer.sv
module capTimer
  import capTimerPkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic [PSEL_W-1:0] prescSel,
  input  logic [1:0]        edgeSel0,
  input  logic [1:0]        edgeSel1,
  input  logic              trigIn0,
  input  logic              trigIn1,
  output logic [CNT_W-1:0]  countVal,
  output logic [CNT_W-1:0]  capVal0,
  output logic [CNT_W-1:0]  capVal1,
  output logic              capFlag0,
  output logic              capFlag1,
  output logic              ovfFlag
);

  localparam logic [CNT_W-1:0] ONE_STEP = CNT_W'(1);

  dpStrobe_t strobe;

  capTimerCtrl #(.PSEL_W(PSEL_W)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .evtMode (modeSel),
    .prescSel(prescSel),
    .pins    ({trigIn1, trigIn0}),
    .edgeSel0(edgeSel_e'(edgeSel0)),
    .edgeSel1(edgeSel_e'(edgeSel1)),
    .strobe  (strobe)
  );

  capTimerDp #(.CNT_W(CNT_W)) uDp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .cntQ  (countVal),
    .cap0Q (capVal0),
    .cap1Q (capVal1),
    .flag0Q(capFlag0),
    .flag1Q(capFlag1),
    .ovfQ  (ovfFlag)
  );

  AST_FREE_RUN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !modeSel |=> (countVal == $past(countVal) + ONE_STEP)); // R2

  AST_EVT_NO_CAP0: assert property (@(posedge clk) disable iff (!rstN)
    capFlag0 |-> !$past(modeSel)); // R7

endmodule

// File: tb/capTimer_tb_top.sv
`timescale 1ns/1ps
module capTimer_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        modeSel;
  logic [1:0]  prescSel;
  logic [1:0]  edgeSel0;
  logic [1:0]  edgeSel1;
  logic [1:0]  pins;
  logic [15:0] countVal;
  logic [15:0] capVal0;
  logic [15:0] capVal1;
  logic        capFlag0;
  logic        capFlag1;
  logic        ovfFlag;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  capTimer dut_i (
    .clk     (clk),
    .rstN    (rstN),
    .modeSel (modeSel),
    .prescSel(prescSel),
    .edgeSel0(edgeSel0),
    .edgeSel1(edgeSel1),
    .trigIn0 (pins[0]),
    .trigIn1 (pins[1]),
    .countVal(countVal),
    .capVal0 (capVal0),
    .capVal1 (capVal1),
    .capFlag0(capFlag0),
    .capFlag1(capFlag1),
    .ovfFlag (ovfFlag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int capOf(input int ch);
    return ch ? int'(capVal1) : int'(capVal0);
  endfunction

  function automatic bit flagOf(input int ch);
    return ch ? capFlag1 : capFlag0;
  endfunction

  // Drive one level change on a channel in free-run mode and watch both channels
  task automatic edgeTrial(input int ch, input bit lvl, input int expHits, input string req);
    int c0, otherCap, hits, otherHits, firstK, capSeen, d, lat;
    d = 1 << prescSel;
    @(negedge clk);
    c0 = int'(countVal);
    otherCap = capOf(1 - ch);
    pins[ch] = lvl;
    hits = 0; otherHits = 0; firstK = 0; capSeen = 0;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      if (flagOf(ch)) begin
        hits++;
        if (firstK == 0) begin
          firstK = k;
          capSeen = capOf(ch);
        end
      end
      if (flagOf(1 - ch)) otherHits++;
    end
    chk(hits == expHits, {req, " flag count (R9 one-cycle pulse)"}, hits, expHits);
    chk(otherHits == 0, "R8 other channel flag quiet", otherHits, 0);
    chk(capOf(1 - ch) == otherCap, "R8 other channel register held", capOf(1 - ch), otherCap);
    if (expHits == 1 && firstK != 0) begin
      lat = firstK - 1;
      chk(capSeen == ((c0 + lat) & 16'hFFFF), "R5 capture equals count of accepting cycle",
          capSeen, (c0 + lat) & 16'hFFFF);
      chk(lat >= d + 2 && lat <= 2 * d + 1, "R6 capture delay within sample window", lat, d + 2);
    end
  endtask

  // Pulse high for a given number of clocks, count flags on the channel
  task automatic glitchTrial(input int ch, input int width, input int expHits, input string req);
    int hits;
    hits = 0;
    @(negedge clk);
    pins[ch] = 1'b1;
    for (int k = 0; k < width; k++) begin
      @(negedge clk);
      if (flagOf(ch)) hits++;
    end
    pins[ch] = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (flagOf(ch)) hits++;
    end
    chk(hits == expHits, req, hits, expHits);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(countVal == 16'd0 || countVal == 16'd1, "R1 counter at reset", countVal, 0);
    chk(capVal0 == 16'd0, "R1 capVal0 at reset", capVal0, 0);
    chk(capVal1 == 16'd0, "R1 capVal1 at reset", capVal1, 0);
    chk(!capFlag0 && !capFlag1 && !ovfFlag, "R1 flags at reset",
        {capFlag0, capFlag1, ovfFlag}, 0);
  endtask

  task automatic testFreeCount();
    int prev;
    @(negedge clk);
    prev = int'(countVal);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(int'(countVal) == ((prev + 1) & 16'hFFFF), "R2 free-run step", countVal, prev + 1);
      prev = int'(countVal);
    end
  endtask

  task automatic testEdgeSelect();
    prescSel = 2'd0;
    edgeSel0 = 2'b01;
    edgeTrial(0, 1'b1, 1, "R3 rising select takes rise");
    edgeTrial(0, 1'b0, 0, "R3 rising select ignores fall");
    edgeSel1 = 2'b10;
    edgeTrial(1, 1'b1, 0, "R3 falling select ignores rise");
    edgeTrial(1, 1'b0, 1, "R3 falling select takes fall");
    edgeSel0 = 2'b11;
    edgeTrial(0, 1'b1, 1, "R3 both select takes rise");
    edgeTrial(0, 1'b0, 1, "R3 both select takes fall");
    edgeSel1 = 2'b00;
    edgeTrial(1, 1'b1, 0, "R3 none select ignores rise");
    edgeTrial(1, 1'b0, 0, "R3 none select ignores fall");
  endtask

  task automatic testFilter();
    prescSel = 2'd0;
    edgeSel0 = 2'b11;
    glitchTrial(0, 1, 0, "R4 one-cycle glitch rejected");
    glitchTrial(0, 2, 2, "R4 two-cycle pulse accepted");
    prescSel = 2'd2;
    edgeSel1 = 2'b11;
    glitchTrial(1, 3, 0, "R4 three-cycle pulse rejected at divide-by-4");
  endtask

  task automatic testPrescaler();
    edgeSel1 = 2'b01;
    for (int p = 1; p < 4; p++) begin
      prescSel = 2'(p);
      edgeTrial(1, 1'b1, 1, "R6 prescaled rise capture");
      edgeTrial(1, 1'b0, 0, "R6 prescaled fall ignored");
    end
    prescSel = 2'd0;
  endtask

  task automatic testEventMode();
    int c, flags0, flags1, capSeen;
    @(negedge clk);
    modeSel  = 1'b1;
    prescSel = 2'd3;
    edgeSel0 = 2'b01;
    @(negedge clk);
    c = int'(countVal);
    flags0 = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (capFlag0) flags0++;
    end
    chk(int'(countVal) == c, "R7 counter holds with idle pin", countVal, c);
    for (int n = 0; n < 5; n++) begin
      pins[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (capFlag0) flags0++; end
      pins[0] = 1'b0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (capFlag0) flags0++; end
    end
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (capFlag0) flags0++; end
    chk(int'(countVal) == c + 5, "R7 rising events counted on undivided clock", countVal, c + 5);
    edgeSel0 = 2'b11;
    for (int n = 0; n < 2; n++) begin
      pins[0] = 1'b1;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (capFlag0) flags0++; end
      pins[0] = 1'b0;
      for (int k = 0; k < 3; k++) begin @(negedge clk); if (capFlag0) flags0++; end
    end
    for (int k = 0; k < 6; k++) begin @(negedge clk); if (capFlag0) flags0++; end
    chk(int'(countVal) == c + 9, "R7 both-edge events counted", countVal, c + 9);
    chk(flags0 == 0, "R7 pin 0 raises no capture flag in event mode", flags0, 0);
    // Pin 1 still captures the (static) event count
    prescSel = 2'd0;
    edgeSel1 = 2'b01;
    flags1 = 0; capSeen = -1;
    pins[1] = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (capFlag1) begin flags1++; capSeen = int'(capVal1); end
    end
    chk(flags1 == 1, "R8 pin 1 captures in event mode", flags1, 1);
    chk(capSeen == c + 9, "R8 event-mode capture value", capSeen, c + 9);
    pins[1] = 1'b0;
    repeat (8) @(negedge clk);
    modeSel = 1'b0;
    @(negedge clk);
  endtask

  task automatic testWrap();
    int guard;
    guard = 0;
    @(negedge clk);
    while (countVal != 16'hFFFF && guard < 70000) begin
      @(negedge clk);
      guard++;
    end
    chk(countVal == 16'hFFFF, "R2 reached FFFFh", countVal, 16'hFFFF);
    chk(!ovfFlag, "R2 no overflow before wrap", ovfFlag, 0);
    @(negedge clk);
    chk(countVal == 16'h0000, "R2 wraps to zero", countVal, 0);
    chk(ovfFlag, "R2 overflow flag on wrap", ovfFlag, 1);
    @(negedge clk);
    chk(!ovfFlag, "R2 overflow flag one cycle", ovfFlag, 0);
  endtask

  initial begin
    rstN = 1'b0;
    modeSel = 1'b0;
    prescSel = 2'd0;
    edgeSel0 = 2'b00;
    edgeSel1 = 2'b00;
    pins = 2'b00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testFreeCount();
    testEdgeSelect();
    testFilter();
    testPrescaler();
    testEventMode();
    testWrap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule